// File: doc/BRIEF.md
# Decimating Complex Sum-of-Products Filter

The block is a time-multiplexed FIR filter for complex baseband data. Each accepted input sample (a 20-bit I value and a 20-bit Q value) is written into a pair of circular sample stores that keep the most recent 160 samples. Every M-th input starts a computation. During a computation, one multiply-accumulate engine per rail steps through the stored history, one tap per clock. It starts at the oldest sample and walks towards the newest. Both rails read the same coefficient in any given clock, taken from a 256-word programmable coefficient store.

Software programs the block through a single write port. Half of the address space is a 128-word window onto the coefficient store; a page bit chooses which half of the store the window reaches. The other half holds the control registers: decimation, counter phase, tap count, coefficient start address and page. The start address works as a pointer, so several filters can be kept loaded and one of them chosen per computation. Zero-padded filters plus a shifted start address give fine steps in timing. The phase preload gives coarse steps in timing.

Each result is rounded to nearest, saturated to 24 bits and presented with a one-cycle strobe. If a start request arrives while the engine is still busy, the request is dropped and a sticky flag is raised.

Top module: `iq_decim_fir`

## Requirements
- R1: After reset, out_vld, overrun, out_i and out_q are all 0, and every sample slot and coefficient word reads as zero.
- R2: The tap count N equals the length register plus one. Values above 159 are treated as 159, so at most 160 taps are used. Each computation uses the N most recent samples, the newest being the sample that triggered it.
- R3: A write with cfg_addr[7]=0 stores cfg_wdata (20-bit two's complement) at coefficient address {page, cfg_addr[6:0]}, where page is the current page bit.
- R4: A write with cfg_addr[7]=1 targets the control register picked by cfg_addr[2:0], using the low bits of cfg_wdata: 0 = decimation minus one (8 bits), 1 = phase preload (8 bits), 2 = tap count minus one (8 bits), 3 = coefficient start address (8 bits), 4 = page bit (bit 0).
- R5: Each accepted input advances an 8-bit decimation counter. When the counter is at or above the decimation register, that input triggers a computation and the counter returns to 0. Otherwise the counter increments. The output rate is therefore the input rate divided by (register+1).
- R6: Writing the phase register loads its value straight into the decimation counter. For example, with decimation register 3 and phase 2, the second input after the write is the one that triggers.
- R7: The result on each rail is the sum over k=0..N-1 of coef[(start+k) mod 256] times sample[newest−N+1+k]. I and Q use identical coefficients.
- R8: The full-precision sum is divided by 2^16 with round-half-up, then clamped to the range −8388608..8388607.
- R9: For a trigger accepted in cycle T, out_vld is high for exactly one cycle, in cycle T+N+1. out_i and out_q hold their values until the next result.
- R10: A trigger that arrives while a computation is running (up to and including its last-tap cycle) produces no output and sets overrun. Once set, overrun stays at 1 until reset. The triggering sample is still stored.
- R11: The start address and tap count are captured when a computation starts. Writes to either register during a computation affect only later computations.
- R12: Coefficient addresses wrap modulo 256, so a filter may cross the page boundary or wrap from 255 to 0 with no special handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | 20 | In-phase input sample, two's complement |
| in_q | input | 20 | Quadrature input sample, two's complement |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Bit 7 selects control (1) or coefficient window (0) |
| cfg_wdata | input | 20 | Configuration write data |
| out_vld | output | 1 | One-cycle result strobe |
| out_i | output | 24 | In-phase result |
| out_q | output | 24 | Quadrature result |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
The hardest conditions to reach from the ports are those that depend on timing within a computation. Examples are a trigger landing while the engine is still mid-sum, or a start-address write that arrives after a computation has captured its pointer. The bench reaches them by deliberately shortening the idle gap between inputs to zero and by issuing register writes in the cycles right after a trigger. Taps that cross the page boundary and the 255-to-0 wrap are reached by programming start addresses near those edges with long filters. Saturation is reached by filling a coefficient region with full-scale values and feeding full-scale samples.

// File: rtl/iq_fir_pkg.sv
`timescale 1ns/1ps
package iq_fir_pkg;

    // Control register selector, cfg_addr[2:0] when cfg_addr[MSB] is set
    typedef enum logic [2:0] {
        CR_DECIM = 3'd0,
        CR_PHASE = 3'd1,
        CR_LEN   = 3'd2,
        CR_OFFS  = 3'd3,
        CR_PAGE  = 3'd4
    } creg_e;

endpackage

// File: rtl/iq_ring.sv
`timescale 1ns/1ps
module iq_ring #(
    parameter int DW    = 20,
    parameter int DEPTH = 160,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wi,
    input  logic [DW-1:0] wq,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] ri,
    output logic [DW-1:0] rq
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mi_q [DEPTH];
    logic [DW-1:0] mq_q [DEPTH];
    logic [DW-1:0] mi_d [DEPTH];
    logic [DW-1:0] mq_d [DEPTH];

    always_comb begin
        mi_d = mi_q;
        mq_d = mq_q;
        if (we) begin
            mi_d[waddr] = wi;
            mq_d[waddr] = wq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                mi_q[s] <= '0;
                mq_q[s] <= '0;
            end
        end else begin
            mi_q <= mi_d;
            mq_q <= mq_d;
        end
    end

    assign ri = mi_q[raddr];
    assign rq = mq_q[raddr];

    // R2: writes only land inside the 160-slot store
    a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> waddr <= LAST);
    a_r2_read_range: assert property (@(posedge clk) disable iff (!rst_n)
        raddr <= LAST);

endmodule

// File: rtl/iq_coef_ram.sv
`timescale 1ns/1ps
module iq_coef_ram #(
    parameter int CW     = 20,
    parameter int CDEPTH = 256,
    localparam int CAW   = $clog2(CDEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [CAW-1:0] waddr,
    input  logic [CW-1:0]  wdata,
    input  logic [CAW-1:0] raddr,
    output logic [CW-1:0]  rdata
);
    logic [CW-1:0] cm_q [CDEPTH];
    logic [CW-1:0] cm_d [CDEPTH];

    always_comb begin
        cm_d = cm_q;
        if (we) cm_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < CDEPTH; a++) cm_q[a] <= '0;
        end else begin
            cm_q <= cm_d;
        end
    end

    assign rdata = cm_q[raddr];

    // R3: a word not addressed by a write keeps its value
    a_r3_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || waddr != raddr) |=> (cm_q[$past(raddr)] == $past(rdata)));

endmodule

// File: rtl/iq_mac.sv
`timescale 1ns/1ps
module iq_mac #(
    parameter int DW    = 20,
    parameter int CW    = 20,
    parameter int OW    = 24,
    parameter int ACC_W = 48,
    parameter int SHIFT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          first,
    input  logic          last,
    input  logic [DW-1:0] smp,
    input  logic [CW-1:0] cf,
    output logic [OW-1:0] res
);
    localparam int PRW = DW + CW;
    localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HALF = ONE <<< (SHIFT - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ONE <<< (OW - 1)) - ONE;
    localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [OW-1:0]           res;
    } mac_t;

    mac_t q, d;
    logic signed [PRW-1:0]   prod;
    logic signed [ACC_W-1:0] prod_x, sum, rnd, shf;

    always_comb begin
        d      = q;
        prod   = $signed(smp) * $signed(cf);
        prod_x = {{(ACC_W - PRW){prod[PRW-1]}}, prod};
        sum    = (first ? '0 : q.acc) + prod_x;
        rnd    = sum + HALF;
        shf    = rnd >>> SHIFT;
        if (en) begin
            d.acc = sum;
            if (last) begin
                if (shf > MAXV)      d.res = OW'(MAXV);
                else if (shf < MINV) d.res = OW'(MINV);
                else                 d.res = OW'(shf);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res = q.res;

    // R7: the running sum only moves while a tap is being processed
    a_r7_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q.acc));
    // R9: the result register holds between final taps
    a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && last) |=> $stable(res));

endmodule

// File: rtl/iq_decim_fir.sv
`timescale 1ns/1ps
module iq_decim_fir
    import iq_fir_pkg::*;
#(
    parameter int DW     = 20,
    parameter int CW     = 20,
    parameter int OW     = 24,
    parameter int DEPTH  = 160,
    parameter int CDEPTH = 256,
    parameter int CTRL_W = 8,
    parameter int ACC_W  = 48,
    parameter int SHIFT  = 16,
    localparam int PW    = $clog2(DEPTH),
    localparam int CAW   = $clog2(CDEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [DW-1:0]  in_i,
    input  logic [DW-1:0]  in_q,
    input  logic           cfg_we,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [CW-1:0]  cfg_wdata,
    output logic           out_vld,
    output logic [OW-1:0]  out_i,
    output logic [OW-1:0]  out_q,
    output logic           overrun
);
    localparam logic [PW-1:0]     LAST_SLOT = PW'(DEPTH - 1);
    localparam logic [CTRL_W-1:0] LEN_CAP   = CTRL_W'(DEPTH - 1);

    typedef struct packed {
        logic [CTRL_W-1:0] dec_m1;
        logic [CTRL_W-1:0] len_m1;
        logic [CAW-1:0]    offs;
        logic              page;
        logic [CTRL_W-1:0] dcnt;
        logic [PW-1:0]     wr;
        logic [PW-1:0]     rd;
        logic [PW-1:0]     tap;
        logic [PW-1:0]     nt;
        logic [CAW-1:0]    caddr;
        logic              busy;
        logic              ovr;
        logic              ovld;
    } st_t;

    st_t q, d;
    logic           fire, coef_we;
    logic [CAW-1:0] coef_waddr;
    logic [PW-1:0]  len_eff, start;
    logic [DW-1:0]  rd_smp [2];
    logic [CW-1:0]  coef;
    logic [OW-1:0]  res [2];

    always_comb begin
        d      = q;
        d.ovld = 1'b0;
        fire   = 1'b0;

        coef_we    = cfg_we && !cfg_addr[CAW-1];
        coef_waddr = {q.page, cfg_addr[CAW-2:0]};

        len_eff = (q.len_m1 > LEN_CAP) ? PW'(LEN_CAP) : PW'(q.len_m1);
        if (q.wr >= len_eff) start = q.wr - len_eff;
        else                 start = q.wr + (LAST_SLOT - len_eff) + PW'(1);

        // input side: store sample, step decimation counter
        if (in_vld) begin
            d.wr = (q.wr == LAST_SLOT) ? '0 : q.wr + PW'(1);
            if (q.dcnt >= q.dec_m1) begin
                d.dcnt = '0;
                fire   = 1'b1;
            end else begin
                d.dcnt = q.dcnt + CTRL_W'(1);
            end
        end

        // control registers
        if (cfg_we && cfg_addr[CAW-1]) begin
            case (creg_e'(cfg_addr[2:0]))
                CR_DECIM: d.dec_m1 = cfg_wdata[CTRL_W-1:0];
                CR_PHASE: d.dcnt   = cfg_wdata[CTRL_W-1:0];
                CR_LEN:   d.len_m1 = cfg_wdata[CTRL_W-1:0];
                CR_OFFS:  d.offs   = cfg_wdata[CAW-1:0];
                CR_PAGE:  d.page   = cfg_wdata[0];
                default:  ;
            endcase
        end

        // tap engine
        if (q.busy) begin
            d.rd    = (q.rd == LAST_SLOT) ? '0 : q.rd + PW'(1);
            d.caddr = q.caddr + CAW'(1);
            d.tap   = q.tap + PW'(1);
            if (q.tap == q.nt) begin
                d.busy = 1'b0;
                d.ovld = 1'b1;
            end
        end

        if (fire) begin
            if (q.busy) begin
                d.ovr = 1'b1;
            end else begin
                d.busy  = 1'b1;
                d.tap   = '0;
                d.nt    = len_eff;
                d.caddr = q.offs;
                d.rd    = start;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    iq_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .we(in_vld), .waddr(q.wr),
        .wi(in_i), .wq(in_q), .raddr(q.rd), .ri(rd_smp[0]), .rq(rd_smp[1])
    );

    iq_coef_ram #(.CW(CW), .CDEPTH(CDEPTH)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_waddr),
        .wdata(cfg_wdata), .raddr(q.caddr), .rdata(coef)
    );

    for (genvar r = 0; r < 2; r++) begin : g_rail
        iq_mac #(.DW(DW), .CW(CW), .OW(OW), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_mac (
            .clk(clk), .rst_n(rst_n), .en(q.busy), .first(q.tap == '0),
            .last(q.tap == q.nt), .smp(rd_smp[r]), .cf(coef), .res(res[r])
        );
    end

    assign out_vld = q.ovld;
    assign out_i   = res[0];
    assign out_q   = res[1];
    assign overrun = q.ovr;

    // R9: result strobe lasts exactly one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld);
    // R10: dropped-trigger flag is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R2: tap index never passes the captured length, which is capped
    a_r2_tap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.tap <= q.nt && q.nt <= LAST_SLOT));
    // R11: captured length cannot change while taps remain
    a_r11_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.tap != q.nt) |=> (q.busy && $stable(q.nt)));

endmodule

// File: tb/sim_iq_decim_fir.sv
`timescale 1ns/1ps
module sim_iq_decim_fir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [19:0] in_i = '0, in_q = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [19:0] cfg_wdata = '0;
    logic        out_vld, overrun;
    logic [23:0] out_i, out_q;

    always #2.5 clk = ~clk;

    iq_decim_fir u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_vld(out_vld), .out_i(out_i), .out_q(out_q), .overrun(overrun)
    );

    int compared = 0, mismatched = 0;
    int cm [256];
    int hi [4096];
    int hq [4096];
    int sn = 0;
    int m_cnt = 0, m_dec = 0, m_len = 0, m_off = 0, cur_page = 0;
    int eq_i [4096];
    int eq_q [4096];
    string eq_tag [4096];
    int head = 0, tail = 0, recv = 0;
    bit skip_next = 0;
    bit prev_vld = 0;
    string cur_req = "R1";
    int cyc = 0;
    bit done = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int srq(input longint s);
        longint r = (s + 64'sd32768) >>> 16;
        if (r > 64'sd8388607) r = 64'sd8388607;
        if (r < -64'sd8388608) r = -64'sd8388608;
        return int'(r);
    endfunction

    function automatic longint dotp(input int newest, input int nt, input int off, input bit rq);
        longint s = 0;
        for (int k = 0; k < nt; k++) begin
            int idx = newest - nt + 1 + k;
            longint x = (idx < 0) ? 0 : (rq ? hq[idx] : hi[idx]);
            s += x * longint'(cm[(off + k) % 256]);
        end
        return s;
    endfunction

    function automatic int gen(input int n, input int salt);
        return ((n * 104729 + salt * 7919) % 1000001) - 500000;
    endfunction

    task automatic wreg(input int idx, input int val);
        cfg_we = 1; cfg_addr = 8'(8'h80 + idx); cfg_wdata = 20'(val);
        @(negedge clk);
        cfg_we = 0;
        case (idx)
            0: m_dec = val & 255;
            1: m_cnt = val & 255;
            2: m_len = val & 255;
            3: m_off = val & 255;
            4: cur_page = val & 1;
            default: ;
        endcase
    endtask

    task automatic wcoef(input int a, input int v);
        if (cur_page != (a >> 7)) wreg(4, a >> 7);
        cfg_we = 1; cfg_addr = 8'(a & 127); cfg_wdata = 20'(v);
        @(negedge clk);
        cfg_we = 0;
        cm[a] = v;
    endtask

    task automatic push(input int vi, input int vq, input int gap);
        in_vld = 1; in_i = 20'(vi); in_q = 20'(vq);
        hi[sn] = vi; hq[sn] = vq; sn++;
        if (m_cnt >= m_dec) begin
            int nt = (m_len > 159) ? 160 : m_len + 1;
            m_cnt = 0;
            if (!skip_next) begin
                eq_i[tail] = srq(dotp(sn - 1, nt, m_off, 0));
                eq_q[tail] = srq(dotp(sn - 1, nt, m_off, 1));
                eq_tag[tail] = cur_req;
                tail++;
            end
            skip_next = 0;
        end else begin
            m_cnt++;
        end
        @(negedge clk);
        in_vld = 0;
        repeat (gap) @(negedge clk);
    endtask

    // result monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_vld && prev_vld) chk("R9 pulse", 1, 0);
            if (out_vld) begin
                recv++;
                if (head >= tail) begin
                    chk("R10 unexpected output", 1, 0);
                end else begin
                    chk({eq_tag[head], " I"}, longint'($signed(out_i)), eq_i[head]);
                    chk({eq_tag[head], " Q"}, longint'($signed(out_q)), eq_q[head]);
                    head++;
                end
            end
            prev_vld = out_vld;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            mismatched++; compared++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int rc;
        int ms [4] = '{1, 2, 3, 5};
        int ns [5] = '{1, 2, 3, 7, 16};
        for (int a = 0; a < 256; a++) cm[a] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_vld", out_vld, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 out_i", out_i, 0);
        chk("R1 out_q", out_q, 0);
        rst_n = 1;
        @(negedge clk);

        // R3: load both pages through the window
        cur_req = "R3";
        for (int a = 0; a < 256; a++) wcoef(a, ((a * 7919 + 13) % 4001) - 2000);

        // R4 R5 R7: sweep decimation and length
        cur_req = "R4 R5 R7";
        foreach (ms[mi]) foreach (ns[ni]) begin
            wreg(0, ms[mi] - 1);
            wreg(2, ns[ni] - 1);
            wreg(3, (ms[mi] * ns[ni] * 9) % 256);
            for (int s = 0; s < 12; s++) push(gen(sn, 1), gen(sn, 2), ns[ni] + 2);
        end

        // R12: wrap 255 -> 0
        cur_req = "R12";
        wreg(0, 0); wreg(2, 11); wreg(3, 250);
        for (int s = 0; s < 4; s++) push(gen(sn, 3), gen(sn, 4), 14);
        // R3 R12: long filter across the page boundary
        cur_req = "R3 R12";
        wreg(0, 1); wreg(2, 139); wreg(3, 60);
        for (int s = 0; s < 6; s++) push(gen(sn, 5), gen(sn, 6), 142);
        // R2: full depth, then a capped length
        cur_req = "R2";
        wreg(0, 0); wreg(2, 159); wreg(3, 5);
        for (int s = 0; s < 3; s++) push(gen(sn, 7), gen(sn, 8), 162);
        wreg(2, 230);
        for (int s = 0; s < 3; s++) push(gen(sn, 9), gen(sn, 10), 162);

        // R11: start-address write during a computation
        cur_req = "R11";
        wreg(2, 19); wreg(3, 10);
        push(gen(sn, 11), gen(sn, 12), 0);
        wreg(3, 100);
        repeat (25) @(negedge clk);
        push(gen(sn, 13), gen(sn, 14), 25);

        // R6: phase preload
        cur_req = "R6";
        wreg(0, 3); wreg(1, 2);
        rc = recv;
        push(gen(sn, 15), gen(sn, 16), 25);
        chk("R6 no output after first input", recv, rc);
        push(gen(sn, 17), gen(sn, 18), 25);
        chk("R6 output after second input", recv, rc + 1);
        wreg(1, 200);
        push(gen(sn, 19), gen(sn, 20), 25);
        chk("R6 phase above limit fires next", recv, rc + 2);

        // R8: rounding half-up
        cur_req = "R8 round";
        wreg(0, 0); wreg(2, 0); wreg(3, 0);
        wcoef(0, 1);
        push(32768, 98304, 4);
        push(32767, -98304, 4);
        push(-32768, 98303, 4);
        push(-32769, -98305, 4);
        // R8: saturation both ways
        cur_req = "R8 sat";
        for (int a = 0; a < 16; a++) wcoef(a, 524287);
        wreg(2, 15);
        for (int s = 0; s < 16; s++) push(524287, -524288, 18);
        chk("R8 positive clamp", longint'($signed(out_i)), 8388607);
        chk("R8 negative clamp", longint'($signed(out_q)), -8388608);

        // R10: trigger during computation
        cur_req = "R10";
        chk("R10 flag clear before", overrun, 0);
        wreg(2, 9);
        rc = recv;
        push(gen(sn, 21), gen(sn, 22), 0);
        skip_next = 1;
        push(gen(sn, 23), gen(sn, 24), 15);
        chk("R10 one output only", recv, rc + 1);
        chk("R10 flag set", overrun, 1);
        push(gen(sn, 25), gen(sn, 26), 15);
        chk("R10 flag sticky", overrun, 1);

        repeat (20) @(negedge clk);
        chk("R9 all results seen", head, tail);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule